// File: doc/BRIEF.md
# ECC Error Log Capture Register

This block sits beside a memory pipeline's ECC checker and keeps a record of the first memory error it reports. Each reported event carries a type (correctable or uncorrectable), a 39-bit byte address and a 16-bit syndrome. The block packs them into one 64-bit log word. While the log holds an event, later events cannot overwrite its address or syndrome. An uncorrectable event still marks the log as uncorrectable, so a fatal error is never hidden behind an earlier benign one.

Beside the log sits a pair of 16-bit registers. The status register flags every event by type. The command register enables, per type, a level interrupt. Software reads the log and the status, then writes ones to the type bits to release them. The interrupt stays high until the enabled status bits are cleared. Access uses a plain select/write/read port with a combinational read path.

Top module: `ecc_err_capture`

## Requirements
- R1: While reset is held at a clock edge, the log, status and command registers become zero and `irq` is low.
- R2: A register select of 0 reads the log, 1 the status, 2 the command register, and 3 reads as zero. Status and command read zero-extended to 64 bits.
- R3: An event arriving while no log type bit is held fills the log. Bit 62 is set for correctable, bit 63 for uncorrectable. Bits 38:5 take address bits 38:5, bits 61:46 take the syndrome, and all other bits read zero.
- R4: While a log type bit is held, a new event leaves log bits 61:5 unchanged, and a correctable event leaves the whole log unchanged.
- R5: An uncorrectable event always leaves log bit 63 set, even while the log is held.
- R6: Writing the log clears bit 62 or 63 where the written bit is 1. Written zeros and all other written bits have no effect, and the address and syndrome fields are kept.
- R7: Every correctable event sets status bit 6 and every uncorrectable event sets status bit 7. Writing a 1 to either bit clears it, and other written bits are ignored.
- R8: Command bits 6 and 7 can be read and written. All other command bits read zero.
- R9: `irq` is high exactly when (status bit 6 AND command bit 6) OR (status bit 7 AND command bit 7), and it stays high until a register write removes that condition.
- R10: When a clear and a new event land in the same cycle, the new event stays recorded. If the clear empties the log, the event's address and syndrome are captured.
- R11: A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Error event strobe, one event per cycle |
| evt_uncorr | input | 1 | Event type: 1 uncorrectable, 0 correctable |
| evt_addr | input | 39 | Byte address of the failing access |
| evt_syndrome | input | 16 | ECC syndrome of the failing access |
| reg_sel | input | 2 | Register select: 0 log, 1 status, 2 command, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data (status and command use bits 15:0) |
| reg_rdata | output | 64 | Combinational read data of the selected register |
| irq | output | 1 | Level interrupt |

## Verification
A table of single events is applied from an empty log. It covers both types, addresses with nonzero low bits, an all-ones address, and all-zero and all-ones syndromes. These cases separate correct field placement and dropping of the low address bits from off-by-one packing. A held-log sequence then applies an uncorrectable event, then a correctable one. It tells the sticky uncorrectable flag apart from field overwrite. Walking clears with zero, non-type and single type bits shows that only the two type bits respond. Enable and status combinations and same-cycle clear-plus-event cases cover the interrupt logic and the priority between clear and event.

// File: rtl/ecc_cap_pkg.sv
// Package: shared bit positions and register select codes for the ECC
// error capture block. Assumes the two type bits are adjacent in both the
// log word and the status word.
package ecc_cap_pkg;
    localparam int LOG_W      = 64;
    localparam int LOG_CE_POS = 62;
    localparam int LOG_UE_POS = 63;
    localparam int LOG_SYN_LO = 46;
    localparam int STS_W      = 16;
    localparam int STS_CE_POS = 6;
    localparam int STS_UE_POS = 7;
    localparam int N_TYPES    = 2;

    typedef enum logic [1:0] {
        SEL_LOG  = 2'd0,
        SEL_STS  = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ecc_log_word.sv
// Module: holds the packed 64-bit error log. It captures address and
// syndrome of the first event, keeps a sticky uncorrectable flag, and
// clears type bits by write-one. Assumes at most one event per cycle and
// that the address field fits below the syndrome field.
module ecc_log_word #(
    parameter int ADDR_W = 39,
    parameter int SYN_W  = 16,
    parameter int GRAN   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        evt_valid,
    input  logic                        evt_uncorr,
    input  logic [ADDR_W-1:0]           evt_addr,
    input  logic [SYN_W-1:0]            evt_syndrome,
    input  logic                        clr_wr,
    input  logic [1:0]                  clr_mask,
    output logic [ecc_cap_pkg::LOG_W-1:0] log_word
);
    import ecc_cap_pkg::*;

    localparam int AFW = ADDR_W - GRAN;

    logic           ce_q, ue_q;
    logic [AFW-1:0] addr_q;
    logic [SYN_W-1:0] syn_q;
    logic           ce_keep, ue_keep, capture;

    // Type bits surviving this cycle's clear, and whether to capture fields.
    always_comb begin
        ce_keep = ce_q & ~(clr_wr & clr_mask[0]);
        ue_keep = ue_q & ~(clr_wr & clr_mask[1]);
        capture = evt_valid & ~(ce_keep | ue_keep);
    end

    // Log state update: event set wins over clear, fields frozen while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            ue_q   <= 1'b0;
            addr_q <= '0;
            syn_q  <= '0;
        end else begin
            ce_q <= ce_keep | (capture & ~evt_uncorr);
            ue_q <= ue_keep | (evt_valid & evt_uncorr);
            if (capture) begin
                addr_q <= evt_addr[ADDR_W-1:GRAN];
                syn_q  <= evt_syndrome;
            end
        end
    end

    // Pack the stored fields into the software-visible word.
    always_comb begin
        log_word                      = '0;
        log_word[LOG_UE_POS]          = ue_q;
        log_word[LOG_CE_POS]          = ce_q;
        log_word[GRAN +: AFW]         = addr_q;
        log_word[LOG_SYN_LO +: SYN_W] = syn_q;
    end
endmodule

// File: rtl/ecc_status_pair.sv
// Module: per-type status flags with write-one clear, per-type enables,
// and the level interrupt. Assumes the type bits sit at STS_CE_POS and
// the next higher bit.
module ecc_status_pair (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          evt_valid,
    input  logic                          evt_uncorr,
    input  logic                          sts_wr,
    input  logic                          cmd_wr,
    input  logic [ecc_cap_pkg::STS_W-1:0] wdata,
    output logic [ecc_cap_pkg::STS_W-1:0] sts_word,
    output logic [ecc_cap_pkg::STS_W-1:0] cmd_word,
    output logic                          irq
);
    import ecc_cap_pkg::*;

    logic [N_TYPES-1:0] sts_q, en_q, hit;

    // Type index 0 is correctable, 1 is uncorrectable.
    always_comb begin
        hit[0] = evt_valid & ~evt_uncorr;
        hit[1] = evt_valid &  evt_uncorr;
    end

    for (genvar t = 0; t < N_TYPES; t++) begin : g_type
        // One status flag and one enable per type.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[t] <= 1'b0;
                en_q[t]  <= 1'b0;
            end else begin
                sts_q[t] <= (sts_q[t] & ~(sts_wr & wdata[STS_CE_POS+t])) | hit[t];
                if (cmd_wr) en_q[t] <= wdata[STS_CE_POS+t];
            end
        end
    end

    // Register views and the interrupt level.
    always_comb begin
        sts_word = '0;
        cmd_word = '0;
        sts_word[STS_CE_POS +: N_TYPES] = sts_q;
        cmd_word[STS_CE_POS +: N_TYPES] = en_q;
        irq = |(sts_q & en_q);
    end
endmodule

// File: rtl/ecc_err_capture.sv
// Module: top of the ECC error capture block. It decodes the register
// port and joins the log word with the status/command pair. Assumes
// reg_wr is a single-cycle strobe and that reads are combinational.
module ecc_err_capture #(
    parameter int ADDR_W = 39,
    parameter int SYN_W  = 16,
    parameter int GRAN   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_uncorr,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [SYN_W-1:0]  evt_syndrome,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq
);
    import ecc_cap_pkg::*;

    reg_sel_e        sel;
    logic            log_wr, sts_wr, cmd_wr;
    logic [LOG_W-1:0] log_word;
    logic [STS_W-1:0] sts_word, cmd_word;

    // Write strobe decode per register.
    always_comb begin
        sel    = reg_sel_e'(reg_sel);
        log_wr = reg_wr && (sel == SEL_LOG);
        sts_wr = reg_wr && (sel == SEL_STS);
        cmd_wr = reg_wr && (sel == SEL_CMD);
    end

    ecc_log_word #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .GRAN(GRAN)) u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid    (evt_valid),
        .evt_uncorr   (evt_uncorr),
        .evt_addr     (evt_addr),
        .evt_syndrome (evt_syndrome),
        .clr_wr       (log_wr),
        .clr_mask     ({reg_wdata[LOG_UE_POS], reg_wdata[LOG_CE_POS]}),
        .log_word     (log_word)
    );

    ecc_status_pair u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_uncorr (evt_uncorr),
        .sts_wr     (sts_wr),
        .cmd_wr     (cmd_wr),
        .wdata      (reg_wdata[STS_W-1:0]),
        .sts_word   (sts_word),
        .cmd_word   (cmd_word),
        .irq        (irq)
    );

    // Read multiplexer.
    always_comb begin
        unique case (sel)
            SEL_LOG: reg_rdata = log_word;
            SEL_STS: reg_rdata = {{(64-STS_W){1'b0}}, sts_word};
            SEL_CMD: reg_rdata = {{(64-STS_W){1'b0}}, cmd_word};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_capture_chk.sv
// Module: property checker bound to the ECC error capture top.
module ecc_err_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_valid,
    input logic        evt_uncorr,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [63:0] log_word,
    input logic [15:0] sts_word,
    input logic        irq
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (log_word == 64'd0 && sts_word == 16'd0 && !irq)); // R1

    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (log_word[63:62] != 2'b00 && !(reg_wr && reg_sel == 2'd0)) |=> $stable(log_word[61:5])); // R4

    AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_uncorr) |=> log_word[63]); // R5

    AST_CE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_uncorr) |=> sts_word[6]); // R7

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq); // R9
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_uncorr (evt_uncorr),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .log_word   (log_word),
    .sts_word   (sts_word),
    .irq        (irq)
);

// File: tb/ecc_err_capture_bench.sv
module ecc_err_capture_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        uc;
        logic [38:0] addr;
        logic [15:0] syn;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 39'h00_1234_5678, 16'hBEEF},
        '{1'b1, 39'h7F_FFFF_FFFF, 16'h0000},
        '{1'b0, 39'h00_0000_001F, 16'hFFFF},
        '{1'b1, 39'h40_0000_0020, 16'hA5A5},
        '{1'b0, 39'h00_0000_0000, 16'h0001},
        '{1'b1, 39'h2A_AAAA_AAA7, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0, evt_uncorr = 1'b0;
    logic [38:0] evt_addr = '0;
    logic [15:0] evt_syndrome = '0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    logic [63:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_capture u_ecc_err_capture (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_uncorr(evt_uncorr),
        .evt_addr(evt_addr), .evt_syndrome(evt_syndrome), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [63:0] exp_log(input logic ue, input logic ce,
                                            input logic [38:0] a, input logic [15:0] s);
        logic [63:0] r;
        r = '0;
        r[63] = ue;
        r[62] = ce;
        r[38:5] = a[38:5];
        r[61:46] = s;
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // One clock cycle with optional write and optional event.
    task automatic cyc(input logic wr, input logic [1:0] sel, input logic [63:0] wd,
                       input logic ev, input logic ue, input logic [38:0] a, input logic [15:0] s);
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        evt_valid = ev; evt_uncorr = ue; evt_addr = a; evt_syndrome = s;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; evt_valid = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [63:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R1 log", v, 64'd0);
        rd(2'd1, v); chk("R1 status", v, 64'd0);
        rd(2'd2, v); chk("R1 command", v, 64'd0);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        rst_n = 1'b1;

        // Table walk: each vector from an empty log (R3, R7, R2 selects).
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 2'd0, '1, 1'b0, 1'b0, '0, '0);
            cyc(1'b1, 2'd1, 64'hFFFF, 1'b0, 1'b0, '0, '0);
            cyc(1'b0, 2'd0, '0, 1'b1, VEC[i].uc, VEC[i].addr, VEC[i].syn);
            rd(2'd0, v);
            chk("R3 capture", v, exp_log(VEC[i].uc, ~VEC[i].uc, VEC[i].addr, VEC[i].syn));
            rd(2'd1, v);
            chk("R7 status type", v, VEC[i].uc ? 64'h80 : 64'h40);
        end

        // Held log behaviour.
        cyc(1'b1, 2'd0, '1, 1'b0, 1'b0, '0, '0);
        cyc(1'b1, 2'd1, 64'hFFFF, 1'b0, 1'b0, '0, '0);
        cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 39'h12_3456_789F, 16'h1111);
        rd(2'd0, v); chk("R3 first ce", v, exp_log(0, 1, 39'h12_3456_789F, 16'h1111));
        cyc(1'b0, 2'd0, '0, 1'b1, 1'b1, 39'h0F_0F0F_0F0F, 16'h2222);
        rd(2'd0, v); chk("R5 ue sticky while held", v, exp_log(1, 1, 39'h12_3456_789F, 16'h1111));
        cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 39'h01_0101_0101, 16'h3333);
        rd(2'd0, v); chk("R4 ce ignored while held", v, exp_log(1, 1, 39'h12_3456_789F, 16'h1111));

        // Write-one clear of log type bits (R6).
        cyc(1'b1, 2'd0, 64'd0, 1'b0, 1'b0, '0, '0);
        rd(2'd0, v); chk("R6 zero write", v, exp_log(1, 1, 39'h12_3456_789F, 16'h1111));
        cyc(1'b1, 2'd0, ~(64'h3 << 62), 1'b0, 1'b0, '0, '0);
        rd(2'd0, v); chk("R6 non-type bits", v, exp_log(1, 1, 39'h12_3456_789F, 16'h1111));
        cyc(1'b1, 2'd0, 64'h1 << 62, 1'b0, 1'b0, '0, '0);
        rd(2'd0, v); chk("R6 clear ce", v, exp_log(1, 0, 39'h12_3456_789F, 16'h1111));
        cyc(1'b1, 2'd0, 64'h1 << 63, 1'b0, 1'b0, '0, '0);
        rd(2'd0, v); chk("R6 clear ue", v, exp_log(0, 0, 39'h12_3456_789F, 16'h1111));

        // Status clear (R7).
        rd(2'd1, v); chk("R7 both set", v, 64'hC0);
        cyc(1'b1, 2'd1, 64'hFF3F_0040, 1'b0, 1'b0, '0, '0);
        rd(2'd1, v); chk("R7 clear bit6", v, 64'h80);

        // Command register and interrupt (R8, R9).
        cyc(1'b1, 2'd2, '1, 1'b0, 1'b0, '0, '0);
        rd(2'd2, v); chk("R8 command bits", v, 64'hC0);
        chk("R9 irq ue enabled", {63'd0, irq}, 64'd1);
        cyc(1'b1, 2'd2, 64'h40, 1'b0, 1'b0, '0, '0);
        chk("R9 irq masked", {63'd0, irq}, 64'd0);
        cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 39'h33_0000_1240, 16'h4444);
        chk("R9 irq ce enabled", {63'd0, irq}, 64'd1);
        rd(2'd0, v); chk("R3 capture after clear", v, exp_log(0, 1, 39'h33_0000_1240, 16'h4444));
        cyc(1'b0, 2'd0, '0, 1'b0, 1'b0, '0, '0);
        chk("R9 irq level holds", {63'd0, irq}, 64'd1);
        cyc(1'b1, 2'd1, 64'h40, 1'b0, 1'b0, '0, '0);
        chk("R9 irq cleared", {63'd0, irq}, 64'd0);

        // Same-cycle clear and event (R10).
        cyc(1'b1, 2'd0, '1, 1'b1, 1'b1, 39'h55_5555_5560, 16'h5555);
        rd(2'd0, v); chk("R10 log event wins", v, exp_log(1, 0, 39'h55_5555_5560, 16'h5555));
        cyc(1'b1, 2'd1, 64'h80, 1'b1, 1'b1, 39'h01_0000_0000, 16'h6666);
        rd(2'd1, v); chk("R10 status event wins", v, 64'h80);
        rd(2'd0, v); chk("R4 held fields", v, exp_log(1, 0, 39'h55_5555_5560, 16'h5555));

        // Unused select (R2, R11).
        rd(2'd3, v); chk("R2 select 3 reads zero", v, 64'd0);
        cyc(1'b1, 2'd3, '1, 1'b0, 1'b0, '0, '0);
        rd(2'd2, v); chk("R11 command kept", v, 64'h40);
        rd(2'd1, v); chk("R11 status kept", v, 64'h80);
        rd(2'd0, v); chk("R11 log kept", v, exp_log(1, 0, 39'h55_5555_5560, 16'h5555));

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule